// File: doc/BRIEF.md
# FIFO Transfer Mode Control with Reset Lock

This block holds the execution-phase transfer settings of a disk controller's data port and produces the request line that asks the processor or DMA engine for each data byte. Three settings are stored. One turns off burst transfers. One makes processor reads bypass the FIFO. One makes processor writes bypass the FIFO. A global FIFO-enable input overrides all three: when it is low, every transfer is a plain unbuffered single-byte exchange.

A lock bit decides what a software reset does to the three settings. When the lock bit is clear, a software reset returns them to their defaults. When it is set, they survive the software reset. A hardware reset always clears the settings and the lock bit.

When a transfer is started, the block works out the effective mode from the enable, the direction and the settings, and latches it. In burst mode the request stays high for the whole run of bytes. In every other case it rises once per byte and stays high until that byte is acknowledged.

Top module: `fifo_xfer_ctrl`

## Requirements
- R1: A hardware reset (rst_n low) clears cfg_q, lock_q, req, busy, mode_burst and mode_fifo to 0, whatever the lock state.
- R2: A cfg_we pulse without soft_rst loads cfg_wdata into cfg_q on the next cycle. The field layout is: bit 0 burst disable, bit 1 read bypass, bit 2 write bypass. A lock_we pulse loads lock_wdata into lock_q.
- R3: A soft_rst pulse while lock_q is 0 clears cfg_q to 0 on the next cycle. lock_q is not changed by a software reset.
- R4: A soft_rst pulse while lock_q is 1 leaves cfg_q unchanged.
- R5: soft_rst takes priority over a cfg_we in the same cycle. It also aborts a running transfer: req and busy are 0 in the following cycle.
- R6: When fifo_en is 0 at start, the transfer runs with mode_fifo=0 and mode_burst=0, whatever cfg_q holds.
- R7: The FIFO path is used when fifo_en is 1 and the bypass bit for the direction is 0. xfer_dir=0 is a read and uses bit 1; xfer_dir=1 is a write and uses bit 2. The other direction's bypass bit has no effect.
- R8: Burst mode (FIFO path used and bit 0 clear) raises req one cycle after start. req then stays high continuously through the acknowledges and falls in the cycle after the acknowledge of the last of xfer_len bytes, giving a single pulse.
- R9: In any other mode each byte gets its own req pulse. req falls in the cycle after the byte's acknowledge and rises again one cycle later if bytes remain, giving xfer_len pulses.
- R10: These inputs have no effect: xfer_start while busy, xfer_start with xfer_len of 0, and byte_ack while req is low. req is never high while busy is low.
- R11: The mode is latched at start. Changing cfg_q during a transfer does not alter mode_burst, mode_fifo or the number of request pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset pulse |
| cfg_we | input | 1 | Settings write strobe |
| cfg_wdata | input | 3 | New settings: bit0 burst off, bit1 read bypass, bit2 write bypass |
| lock_we | input | 1 | Lock bit write strobe |
| lock_wdata | input | 1 | New lock bit value |
| fifo_en | input | 1 | Global FIFO enable |
| xfer_start | input | 1 | Start an execution-phase transfer |
| xfer_dir | input | 1 | 0 processor read, 1 processor write |
| xfer_len | input | LEN_W | Number of bytes in the transfer |
| byte_ack | input | 1 | Acknowledge of one byte, taken while req is high |
| req | output | 1 | Data request to processor or DMA |
| busy | output | 1 | A transfer is in progress |
| mode_burst | output | 1 | Latched burst mode of the running transfer |
| mode_fifo | output | 1 | Latched FIFO-path use of the running transfer |
| cfg_q | output | 3 | Stored settings |
| lock_q | output | 1 | Stored lock bit |

## Verification
The hardest case to reach is a software reset that lands in the middle of a burst while the lock is clear. It has to abort the transfer and clear the settings at once, and the scoreboard must still account for a pulse that never reached its full byte count. The bench reaches it this way: it starts a burst, acknowledges some bytes by hand, then pulses soft_rst and pushes the truncated expectation ahead of time. A second hard case is a settings write and a second start request that arrive while a transfer is in flight. The bench injects both on the cycle of the first acknowledge, so that R11 and R10 are shown on the live request line.

// File: rtl/fxc_pkg.sv
package fxc_pkg;

  typedef struct packed {
    logic wr_byp;   // bit 2
    logic rd_byp;   // bit 1
    logic bst_off;  // bit 0
  } fxc_cfg_t;

  // FIFO path is used when globally enabled and not bypassed for this direction
  function automatic logic fxc_path_on(input logic en, input logic dir, input fxc_cfg_t c);
    logic byp;
    byp = dir ? c.wr_byp : c.rd_byp;
    return en & ~byp;
  endfunction

  // Burst only rides on the FIFO path
  function automatic logic fxc_burst_on(input logic path, input fxc_cfg_t c);
    return path & ~c.bst_off;
  endfunction

endpackage

// File: rtl/fxc_cfg_regs.sv
module fxc_cfg_regs
  import fxc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  logic     cfg_we,
  input  fxc_cfg_t cfg_wdata,
  input  logic     lock_we,
  input  logic     lock_wdata,
  output fxc_cfg_t cfg_q,
  output logic     lock_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (soft_rst) begin
      if (!lock_q) cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_we) lock_q <= lock_wdata;
  end

endmodule

// File: rtl/fxc_mode_decode.sv
module fxc_mode_decode
  import fxc_pkg::*;
(
  input  logic     fifo_en,
  input  logic     dir,
  input  fxc_cfg_t cfg,
  output logic     use_fifo,
  output logic     use_burst
);

  always_comb begin
    use_fifo  = fxc_path_on(fifo_en, dir, cfg);
    use_burst = fxc_burst_on(use_fifo, cfg);
  end

endmodule

// File: rtl/fxc_req_gen.sv
module fxc_req_gen #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             use_fifo,
  input  logic             use_burst,
  input  logic             byte_ack,
  output logic             req,
  output logic             busy,
  output logic             mode_burst,
  output logic             mode_fifo,
  output logic             start_take,
  output logic             ack_take,
  output logic             ack_last
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] remain;
  logic             burst_q;
  logic             fifo_q;

  assign start_take = start & ~busy & (len != '0) & ~soft_rst;
  assign ack_take   = busy & req & byte_ack;
  assign ack_last   = ack_take & (remain == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      req     <= 1'b0;
      remain  <= '0;
      burst_q <= 1'b0;
      fifo_q  <= 1'b0;
    end else if (soft_rst) begin
      busy    <= 1'b0;
      req     <= 1'b0;
      remain  <= '0;
      burst_q <= 1'b0;
      fifo_q  <= 1'b0;
    end else if (start_take) begin
      busy    <= 1'b1;
      req     <= 1'b1;
      remain  <= len;
      burst_q <= use_burst;
      fifo_q  <= use_fifo;
    end else if (ack_last) begin
      busy    <= 1'b0;
      req     <= 1'b0;
      remain  <= '0;
      burst_q <= 1'b0;
      fifo_q  <= 1'b0;
    end else if (ack_take) begin
      remain  <= remain - ONE;
      req     <= burst_q;
    end else if (busy && !req) begin
      req     <= 1'b1;
    end
  end

  assign mode_burst = burst_q;
  assign mode_fifo  = fifo_q;

endmodule

// File: rtl/fifo_xfer_ctrl.sv
module fifo_xfer_ctrl
  import fxc_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_wdata,
  input  logic             lock_we,
  input  logic             lock_wdata,
  input  logic             fifo_en,
  input  logic             xfer_start,
  input  logic             xfer_dir,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             byte_ack,
  output logic             req,
  output logic             busy,
  output logic             mode_burst,
  output logic             mode_fifo,
  output logic [2:0]       cfg_q,
  output logic             lock_q
);

  fxc_cfg_t cfg_s;
  logic     dec_fifo;
  logic     dec_burst;
  logic     start_take;
  logic     ack_take;
  logic     ack_last;

  fxc_cfg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (fxc_cfg_t'(cfg_wdata)),
    .lock_we    (lock_we),
    .lock_wdata (lock_wdata),
    .cfg_q      (cfg_s),
    .lock_q     (lock_q)
  );

  fxc_mode_decode u_dec (
    .fifo_en   (fifo_en),
    .dir       (xfer_dir),
    .cfg       (cfg_s),
    .use_fifo  (dec_fifo),
    .use_burst (dec_burst)
  );

  fxc_req_gen #(.LEN_W(LEN_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .start      (xfer_start),
    .len        (xfer_len),
    .use_fifo   (dec_fifo),
    .use_burst  (dec_burst),
    .byte_ack   (byte_ack),
    .req        (req),
    .busy       (busy),
    .mode_burst (mode_burst),
    .mode_fifo  (mode_fifo),
    .start_take (start_take),
    .ack_take   (ack_take),
    .ack_last   (ack_last)
  );

  assign cfg_q = cfg_s;

endmodule

// File: rtl/fxc_chk.sv
module fxc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       cfg_we,
  input logic [2:0] cfg_wdata,
  input logic [2:0] cfg_q,
  input logic       lock_q,
  input logic       fifo_en,
  input logic       req,
  input logic       busy,
  input logic       mode_burst,
  input logic       mode_fifo,
  input logic       start_take,
  input logic       ack_take,
  input logic       ack_last
);

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !soft_rst |=> cfg_q == $past(cfg_wdata));

  // R3
  unlocked_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !lock_q |=> cfg_q == 3'b000);

  // R4
  locked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && lock_q |=> cfg_q == $past(cfg_q));

  // R5
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !req && !busy);

  // R6
  fifo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_take && !fifo_en |=> !mode_fifo && !mode_burst);

  // R8
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take && !ack_last && mode_burst && !soft_rst |=> req);

  // R9
  single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take && !mode_burst |=> !req);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req);

  // R11
  mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ack_last && !soft_rst |=> $stable(mode_burst) && $stable(mode_fifo));

endmodule

bind fifo_xfer_ctrl fxc_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .cfg_q      (cfg_q),
  .lock_q     (lock_q),
  .fifo_en    (fifo_en),
  .req        (req),
  .busy       (busy),
  .mode_burst (mode_burst),
  .mode_fifo  (mode_fifo),
  .start_take (start_take),
  .ack_take   (ack_take),
  .ack_last   (ack_last)
);

// File: tb/fifo_xfer_ctrl_tb_top.sv
module fifo_xfer_ctrl_tb_top;

  localparam int LEN_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             soft_rst = 1'b0;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_wdata = '0;
  logic             lock_we = 1'b0;
  logic             lock_wdata = 1'b0;
  logic             fifo_en = 1'b1;
  logic             xfer_start = 1'b0;
  logic             xfer_dir = 1'b0;
  logic [LEN_W-1:0] xfer_len = '0;
  logic             byte_ack = 1'b0;
  logic             req, busy, mode_burst, mode_fifo, lock_q;
  logic [2:0]       cfg_q;

  int compared = 0;
  int mismatched = 0;

  typedef struct {
    logic  burst;
    logic  fifo;
    int    pulses;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  fifo_xfer_ctrl #(.LEN_W(LEN_W)) dut_i (.*);

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected mode, restated from the requirements as a lookup
  function automatic logic [1:0] exp_mode(input logic en, input logic dir, input logic [2:0] c);
    logic path;
    case ({en, dir})
      2'b10:   path = (c[1] == 1'b0);
      2'b11:   path = (c[2] == 1'b0);
      default: path = 1'b0;
    endcase
    return {path && (c[0] == 1'b0), path};  // {burst, fifo}
  endfunction

  task automatic write_cfg(input logic [2:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // Driver: pushes expectation, runs a transfer, optionally pokes mid-run
  task automatic run_xfer(input logic dir, input int len, input string tag, input bit poke);
    logic [1:0] m;
    exp_t e;
    int acks;
    m = exp_mode(fifo_en, dir, cfg_q);
    e.burst = m[1]; e.fifo = m[0]; e.pulses = m[1] ? 1 : len; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    xfer_start = 1'b1; xfer_dir = dir; xfer_len = LEN_W'(len);
    @(negedge clk);
    xfer_start = 1'b0;
    acks = 0;
    while (acks < len) begin
      if (req) begin
        byte_ack = 1'b1;
        if (poke && acks == 0) begin
          cfg_we = 1'b1; cfg_wdata = 3'b111;
          xfer_start = 1'b1; xfer_len = LEN_W'(9);
        end
        acks++;
      end else begin
        byte_ack = 1'b0;
      end
      @(negedge clk);
      cfg_we = 1'b0; xfer_start = 1'b0;
    end
    byte_ack = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: counts req pulses per transfer and compares with the scoreboard
  logic prev_busy = 1'b0, prev_req = 1'b0, cap_burst, cap_fifo;
  int   pulses = 0;
  always @(negedge clk) begin
    if (busy && !prev_busy) begin
      cap_burst = mode_burst; cap_fifo = mode_fifo; pulses = 0;
    end
    if (req && !prev_req) pulses++;
    if (prev_busy && !busy) begin
      if (sb_q.size() == 0) begin
        check("R10 unexpected transfer", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " burst"}, int'(cap_burst), int'(e.burst));
        check({e.tag, " fifo"}, int'(cap_fifo), int'(e.fifo));
        check({e.tag, " pulses"}, pulses, e.pulses);
      end
    end
    prev_busy = busy; prev_req = req;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cfg reset", int'(cfg_q), 0);
    check("R1 lock reset", int'(lock_q), 0);
    check("R1 req/busy reset", int'({req, busy}), 0);

    write_cfg(3'b101);
    check("R2 cfg load", int'(cfg_q), 5);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R3 unlocked clear", int'(cfg_q), 0);
    check("R3 lock untouched", int'(lock_q), 0);

    @(negedge clk); lock_we = 1'b1; lock_wdata = 1'b1;
    @(negedge clk); lock_we = 1'b0;
    check("R2 lock load", int'(lock_q), 1);
    write_cfg(3'b111);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R4 locked keep", int'(cfg_q), 7);
    @(negedge clk); lock_we = 1'b1; lock_wdata = 1'b0;
    @(negedge clk); lock_we = 1'b0;
    @(negedge clk); soft_rst = 1'b1; cfg_we = 1'b1; cfg_wdata = 3'b011;
    @(negedge clk); soft_rst = 1'b0; cfg_we = 1'b0;
    check("R5 soft reset beats write", int'(cfg_q), 0);

    // R10: ignored inputs while idle
    @(negedge clk); byte_ack = 1'b1;
    @(negedge clk); byte_ack = 1'b0;
    check("R10 idle ack", int'({req, busy}), 0);
    @(negedge clk); xfer_start = 1'b1; xfer_len = '0;
    @(negedge clk); xfer_start = 1'b0;
    check("R10 zero length", int'({req, busy}), 0);

    run_xfer(1'b0, 4, "R8 burst read", 1'b0);
    write_cfg(3'b001);
    run_xfer(1'b0, 3, "R9 single read", 1'b0);
    write_cfg(3'b010);
    run_xfer(1'b0, 2, "R7 read bypass", 1'b0);
    run_xfer(1'b1, 3, "R7 write unaffected", 1'b0);
    write_cfg(3'b100);
    run_xfer(1'b1, 2, "R7 write bypass", 1'b0);
    fifo_en = 1'b0;
    write_cfg(3'b000);
    run_xfer(1'b0, 3, "R6 fifo off", 1'b0);
    fifo_en = 1'b1;
    run_xfer(1'b1, 3, "R11 R10 mid-run poke", 1'b1);
    check("R11 write landed", int'(cfg_q), 7);

    // R5 abort: burst of 5, two acks, then software reset
    write_cfg(3'b000);
    sb_q.push_back('{burst: 1'b1, fifo: 1'b1, pulses: 1, tag: "R5 abort"});
    @(negedge clk); xfer_start = 1'b1; xfer_dir = 1'b0; xfer_len = LEN_W'(5);
    @(negedge clk); xfer_start = 1'b0; byte_ack = 1'b1;
    @(negedge clk);
    @(negedge clk); byte_ack = 1'b0; soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R5 abort req/busy", int'({req, busy}), 0);

    // R1: hardware reset clears a held lock
    @(negedge clk); lock_we = 1'b1; lock_wdata = 1'b1; cfg_we = 1'b1; cfg_wdata = 3'b110;
    @(negedge clk); lock_we = 1'b0; cfg_we = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 hard reset cfg", int'(cfg_q), 0);
    check("R1 hard reset lock", int'(lock_q), 0);
    check("R10 scoreboard drained", sb_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule